// File: doc/BRIEF.md
# Serial Sampling Converter Power-Mode Front End

This block is the slave-side digital front end of a 14-bit serial sampling converter. It watches an active-low chip select and a serial clock, both already synchronous to the system clock. It samples them on every system clock edge and works from their edges. A falling chip select opens a frame. The 14-bit parallel word from the converter model is captured at that moment and shifted out over 16 serial clock cycles: two leading zeros, then the data MSB first. Each bit changes after a serial clock falling edge, so the master can sample it on the following rising edge.

Alongside the data path, a four-state power-mode machine decides how the part responds when chip select rises. The decision depends on how many serial clock falling edges the frame has seen. Releasing chip select in the middle window of a normal frame aborts the conversion and powers the part down. A release that is too early or too late is taken as a glitch or as a short frame, and the part stays in normal mode. Waking the part needs a dummy frame that holds chip select low past the tenth falling edge and on to the sixteenth. A data-valid flag marks the frames whose data can be trusted.

Top module: `sadc_pwr_ctrl`

## Requirements
- R1: After synchronous reset, `pwr_state_o` reads 2'b00 (normal), `sdo_oe_o` is 0 and `data_valid_o` is 0.
- R2: On a chip select falling edge the block captures `sample_i`. While the frame is open, `sdo_o` first shows two zeros and then `sample_i` bit 13 down to bit 0. Each bit comes k serial clock falling edges after chip select fell, for k = 0 to 15.
- R3: `sdo_oe_o` is 1 while chip select is low and fewer than 16 falling edges have been counted. It is 0 whenever chip select is high and from the 16th falling edge on. Extra clocks in the same frame do not wrap the count and do not re-enable the output.
- R4: In normal mode, a chip select rise after 0 or 1 falling edges leaves the state at normal (2'b00).
- R5: In normal mode, a chip select rise after 2 to 9 falling edges moves the state to powered down (2'b01), and the output stays disabled.
- R6: In normal mode, a chip select rise after 10 or more falling edges leaves the state at normal; the frame is simply cut short.
- R7: When powered down, a chip select fall moves the state to waking (2'b10). A rise after fewer than 10 falling edges, for example a burst of 8, returns it to powered down.
- R8: In a waking frame, the 16th falling edge moves the state to ready (2'b11), and the next chip select rise moves it to normal. A rise after 10 to 15 falling edges leaves the state at waking.
- R9: `data_valid_o` is 1 during a frame only if the state was normal when that frame began. It is 0 during wake-up frames and returns to 1 on the first frame after wake-up completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Chip select, active low, synchronous to clk_i |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i, idles high |
| sample_i | input | 14 | Parallel sample word from the converter model |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pad driver |
| pwr_state_o | output | 2 | Power state: 00 normal, 01 powered down, 10 waking, 11 ready |
| data_valid_o | output | 1 | High during a frame whose data is valid |

## Verification
A wrong edge count moves the boundaries between the early, abort and commit windows. The state output then differs within a few system clocks of the chip select rise that sits on a boundary edge (1/2, 9/10 or 15/16). A corrupted shift register or a counter that wraps shows in the very next serial bit, or as an output enable that comes back after the 16th edge. A wrong transition in the power-mode machine shows as a valid flag that is set during a dummy frame, or missing on the frame after it.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int SAMPLE_W     = 14;
    localparam int LEAD_ZEROS   = 2;
    localparam int FRAME_LEN    = SAMPLE_W + LEAD_ZEROS;
    localparam int ABORT_EDGE   = 2;
    localparam int COMMIT_EDGE  = 10;
    localparam int CNT_W        = $clog2(FRAME_LEN + 1);

    typedef enum logic [1:0] {
        PS_NORMAL = 2'b00,
        PS_DOWN   = 2'b01,
        PS_WAKING = 2'b10,
        PS_READY  = 2'b11
    } pwr_state_t;

    typedef enum logic [1:0] {
        ZONE_EARLY  = 2'b00,
        ZONE_ABORT  = 2'b01,
        ZONE_COMMIT = 2'b10
    } rise_zone_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

    function automatic rise_zone_t rise_zone(input logic [CNT_W-1:0] edges);
        if (edges < CNT_W'(ABORT_EDGE))       return ZONE_EARLY;
        else if (edges < CNT_W'(COMMIT_EDGE)) return ZONE_ABORT;
        else                                  return ZONE_COMMIT;
    endfunction

endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det #(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  sig_i,
    output sadc_pkg::edge_t       edge_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= IDLE_VAL;
        else       prev_q <= sig_i;
    end

    always_comb begin
        edge_o.fall = prev_q & ~sig_i;
        edge_o.rise = ~prev_q & sig_i;
    end
endmodule

// File: rtl/sadc_frame_cnt.sv
module sadc_frame_cnt
    import sadc_pkg::*;
#(
    parameter int LEN = FRAME_LEN,
    localparam int W  = $clog2(LEN + 1)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         start_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                  cnt_q <= '0;
        else if (start_i)           cnt_q <= '0;
        else if (tick_i && !done_o) cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o  = cnt_q;
    assign done_o = (cnt_q == W'(LEN));

    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= W'(LEN));

    assert_cnt_no_wrap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o && !start_i |=> done_o);
endmodule

// File: rtl/sadc_power_fsm.sv
module sadc_power_fsm
    import sadc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  edge_t            cs_edge_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             in_frame_i,
    output pwr_state_t       state_o,
    output logic             valid_o
);
    pwr_state_t state_q, state_d;
    logic       valid_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_NORMAL: begin
                if (cs_edge_i.rise && rise_zone(cnt_i) == ZONE_ABORT)
                    state_d = PS_DOWN;
            end
            PS_DOWN: begin
                if (cs_edge_i.fall) state_d = PS_WAKING;
            end
            PS_WAKING: begin
                if (cs_edge_i.rise) begin
                    if (rise_zone(cnt_i) != ZONE_COMMIT) state_d = PS_DOWN;
                end else if (in_frame_i && cnt_i == CNT_W'(FRAME_LEN)) begin
                    state_d = PS_READY;
                end
            end
            PS_READY: begin
                if (cs_edge_i.rise) state_d = PS_NORMAL;
            end
            default: state_d = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PS_NORMAL;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cs_edge_i.fall)      valid_q <= (state_q == PS_NORMAL);
            else if (cs_edge_i.rise) valid_q <= 1'b0;
        end
    end

    assign state_o = state_q;
    assign valid_o = valid_q;

    assert_down_exit_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == PS_DOWN |=> state_q == PS_DOWN || state_q == PS_WAKING);

    assert_ready_exit_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == PS_READY |=> state_q == PS_READY || state_q == PS_NORMAL);

    assert_normal_exit_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == PS_NORMAL |=> state_q == PS_NORMAL || state_q == PS_DOWN);

    assert_valid_normal_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_q |-> state_q == PS_NORMAL);
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
    import sadc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  edge_t               cs_edge_i,
    input  logic                tick_i,
    input  logic                done_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                in_frame_o,
    output logic                sdo_o,
    output logic                oe_o
);
    logic [FRAME_LEN-1:0] sreg_q;
    logic                 in_frame_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sreg_q     <= '0;
            in_frame_q <= 1'b0;
        end else begin
            if (cs_edge_i.fall) begin
                sreg_q     <= {{LEAD_ZEROS{1'b0}}, sample_i};
                in_frame_q <= 1'b1;
            end else begin
                if (cs_edge_i.rise) in_frame_q <= 1'b0;
                if (tick_i)         sreg_q <= {sreg_q[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    assign in_frame_o = in_frame_q;
    assign sdo_o      = sreg_q[FRAME_LEN-1];
    assign oe_o       = in_frame_q & ~done_i;
endmodule

// File: rtl/sadc_pwr_ctrl.sv
module sadc_pwr_ctrl
    import sadc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                csn_i,
    input  logic                sclk_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic [1:0]          pwr_state_o,
    output logic                data_valid_o
);
    edge_t            cs_edge, sclk_edge;
    logic             tick, done, in_frame;
    logic [CNT_W-1:0] cnt;
    pwr_state_t       state;

    sadc_edge_det #(.IDLE_VAL(1'b1)) u_cs_edge (
        .clk_i(clk_i), .rst_i(rst_i), .sig_i(csn_i), .edge_o(cs_edge));

    sadc_edge_det #(.IDLE_VAL(1'b1)) u_sclk_edge (
        .clk_i(clk_i), .rst_i(rst_i), .sig_i(sclk_i), .edge_o(sclk_edge));

    assign tick = sclk_edge.fall & ~csn_i;

    sadc_frame_cnt #(.LEN(FRAME_LEN)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .start_i(cs_edge.fall), .tick_i(tick),
        .cnt_o(cnt), .done_o(done));

    sadc_power_fsm u_fsm (
        .clk_i(clk_i), .rst_i(rst_i), .cs_edge_i(cs_edge), .cnt_i(cnt),
        .in_frame_i(in_frame), .state_o(state), .valid_o(data_valid_o));

    sadc_shifter u_shift (
        .clk_i(clk_i), .rst_i(rst_i), .cs_edge_i(cs_edge), .tick_i(tick),
        .done_i(done), .sample_i(sample_i), .in_frame_o(in_frame),
        .sdo_o(sdo_o), .oe_o(sdo_oe_o));

    assign pwr_state_o = state;

    assert_oe_cs_high_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        csn_i && $past(csn_i) |-> !sdo_oe_o);

    assert_oe_after_last_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        done |-> !sdo_oe_o);

    assert_lead_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_edge.fall |=> !sdo_o);
endmodule

// File: tb/sadc_pwr_ctrl_tb_top.sv
module sadc_pwr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csn = 1'b1;
    logic        sclk = 1'b1;
    logic [13:0] sample = '0;
    logic        sdo, sdo_oe, data_valid;
    logic [1:0]  pwr_state;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] cap_bits;
    logic        cap_valid, cap_oe_start, cap_oe_end, cap_oe_after;
    logic [1:0]  cap_state_start, cap_state_end;

    always #5 clk = ~clk;

    sadc_pwr_ctrl dut_i (
        .clk_i(clk), .rst_i(rst), .csn_i(csn), .sclk_i(sclk), .sample_i(sample),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pwr_state_o(pwr_state),
        .data_valid_o(data_valid));

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [13:0] s, input int nclk);
        cap_bits = '0;
        sample = s;
        csn = 1'b0;
        wait_clk(3);
        cap_bits[15]    = sdo;
        cap_valid       = data_valid;
        cap_oe_start    = sdo_oe;
        cap_state_start = pwr_state;
        for (int k = 1; k <= nclk; k++) begin
            sclk = 1'b0;
            wait_clk(2);
            if (k < 16) cap_bits[15-k] = sdo;
            sclk = 1'b1;
            wait_clk(2);
        end
        cap_oe_end    = sdo_oe;
        cap_state_end = pwr_state;
        csn = 1'b1;
        wait_clk(3);
        cap_oe_after = sdo_oe;
    endtask

    task automatic t_reset;
        chk("R1", "state", 32'(pwr_state), 32'h0);
        chk("R1", "oe", 32'(sdo_oe), 32'h0);
        chk("R1", "valid", 32'(data_valid), 32'h0);
    endtask

    task automatic t_full_frame(input logic [13:0] s);
        run_frame(s, 16);
        chk("R2", "bits", 32'(cap_bits), 32'({2'b00, s}));
        chk("R3", "oe in frame", 32'(cap_oe_start), 32'h1);
        chk("R3", "oe after 16", 32'(cap_oe_end), 32'h0);
        chk("R9", "valid normal", 32'(cap_valid), 32'h1);
        chk("R6", "state", 32'(pwr_state), 32'h0);
    endtask

    task automatic t_long_frame;
        run_frame(14'h0F0F, 21);
        chk("R3", "oe after 21", 32'(cap_oe_end), 32'h0);
        chk("R3", "oe cs high", 32'(cap_oe_after), 32'h0);
        chk("R2", "bits long", 32'(cap_bits), 32'({2'b00, 14'h0F0F}));
    endtask

    task automatic t_normal_rise(input int n, input logic [1:0] exp, input string req);
        run_frame(14'h1234, n);
        chk(req, $sformatf("state after %0d", n), 32'(pwr_state), 32'(exp));
        chk("R3", "oe after rise", 32'(cap_oe_after), 32'h0);
    endtask

    task automatic t_wake(input int n, input logic [1:0] exp_end, input logic [1:0] exp_after);
        run_frame(14'h2AAA, n);
        chk("R7", "wake start", 32'(cap_state_start), 32'h2);
        chk("R9", "wake valid", 32'(cap_valid), 32'h0);
        chk("R8", $sformatf("state end %0d", n), 32'(cap_state_end), 32'(exp_end));
        chk("R7", $sformatf("state after %0d", n), 32'(pwr_state), 32'(exp_after));
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_full_frame(14'h2A5C);
        t_full_frame(14'h1FFF);
        t_full_frame(14'h0001);
        t_long_frame();
        t_normal_rise(0, 2'b00, "R4");
        t_normal_rise(1, 2'b00, "R4");
        t_normal_rise(10, 2'b00, "R6");
        t_normal_rise(14, 2'b00, "R6");
        t_normal_rise(2, 2'b01, "R5");
        t_wake(8, 2'b10, 2'b01);
        t_wake(9, 2'b10, 2'b01);
        t_wake(10, 2'b10, 2'b10);
        t_wake(2, 2'b10, 2'b01);
        t_wake(12, 2'b10, 2'b10);
        t_wake(16, 2'b11, 2'b00);
        t_full_frame(14'h3C3C);
        t_normal_rise(9, 2'b01, "R5");
        t_wake(20, 2'b11, 2'b00);
        t_full_frame(14'h2222);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1ms;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule